// File: doc/BRIEF.md
# CAN Receive Identifier Acceptance Filter Bank

This block decides, for every identifier word handed up by a CAN receiver, whether the frame should go on into the receive path. It holds a small bank of filters. Each filter has a programmable compare mask and a programmable reference identifier, and an enable bit. An incoming identifier is tested against every enabled filter in parallel. The result is a one-cycle accept or reject pulse, together with the index of the filter that matched.

Software reaches the filters through a plain word-wide write and read port. A filter's mask and reference may only be changed while that filter is disabled and the bank is not busy. Writing the enable register starts a short busy window, and software must wait for the busy status to clear before it reprograms any filter. The identifier word is packed with the 11-bit base identifier at the top, then the substitute/remote bit, the extension flag, the 18-bit extension and a trailing remote bit. Standard frames ignore the extension fields, and a filter whose mask leaves the extension flag clear checks base fields only.

Top module: `can_accept_filter_bank`

## Requirements
- R1: After reset, the enable register, every mask and every reference register read 0, busy_o is 0 and dec_vld is 0.
- R2: The register map is as follows. Address 0 is the enable register, with bit i enabling filter i and the upper bits reading 0. Address 1 is status, with bit 0 being busy. Address 2+2i is the mask of filter i and address 3+2i is its reference. Reads are combinational from reg_addr.
- R3: A write to address 0 raises busy_o starting with the cycle after the write edge, and busy_o stays high for exactly 2 cycles.
- R4: A write to a mask or reference register has no effect while busy_o is 1 or while that filter's enable bit is 1.
- R5: A mask bit of 1 requires the identifier bit to equal the reference bit. A mask bit of 0 makes that bit a don't-care.
- R6: The identifier packing is: bits [31:21] hold the base ID, bit 20 is SRR/RTR, bit 19 is IDE, bits [18:1] hold the extended ID, and bit 0 is the extended RTR. When the frame's bit 19 is 0 (standard frame), bits [18:0] are never compared.
- R7: When bit 19 of a filter's mask is 0, that filter ignores bits [18:0] even for extended frames.
- R8: A frame is accepted when at least one enabled filter matches, and rejected otherwise. A disabled filter never matches.
- R9: With all filters disabled, every frame is accepted with index 0. When no filter matches, the index is 0.
- R10: When several enabled filters match, dec_idx is the lowest-numbered one.
- R11: dec_vld pulses for one cycle, at the first clock edge after the edge that samples frm_vld. dec_acc and dec_idx are valid with it.
- R12: A mask of 0xFFF80000 with a reference of 0xABC00000 accepts a standard frame with base ID 0x55E and SRR 0, and rejects it if SRR is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| busy_o | output | 1 | Filter reconfiguration busy |
| frm_vld | input | 1 | Identifier word valid |
| frm_id | input | 32 | Packed received identifier |
| dec_vld | output | 1 | Decision valid pulse |
| dec_acc | output | 1 | 1 = accept, 0 = reject |
| dec_idx | output | 2 | Index of the matching filter |

## Verification
A register write takes effect on the edge that samples it. Read data follows the address within the same cycle, so the bench checks it a moment after setting the address. busy_o is due in the two cycles after the enable-register write edge and must be low in the third, and the bench samples each of those at the falling edge. A decision is due one edge after the strobe is sampled, so the bench drops the strobe on a falling edge and checks dec_vld, dec_acc and dec_idx at that same falling edge, then confirms dec_vld is low one cycle later. The sweep covers all sixteen enable patterns against forty generated identifiers, which reach standard, extended, overlapping and non-matching cases.

// File: rtl/canaf_pkg.sv
package canaf_pkg;
   // bit positions of the packed identifier word
   localparam int unsigned IDE_POS   = 19;
   localparam int unsigned EXT_BITS  = 19;   // bits [18:0] are extension-only
   // register address map
   localparam int unsigned ADR_ENABLE = 0;
   localparam int unsigned ADR_STATUS = 1;
   localparam int unsigned ADR_FBASE  = 2;

   function automatic logic [31:0] ext_clear(input logic [31:0] m);
      return {m[31:EXT_BITS], {EXT_BITS{1'b0}}};
   endfunction
endpackage

// File: rtl/canaf_regs.sv
module canaf_regs
   import canaf_pkg::*;
#(
   parameter int unsigned NUM_FILT = 4,
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned BUSY_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata,
   output logic [NUM_FILT-1:0] en_o,
   output logic              busy_o,
   output logic [WORD_W-1:0] mask_o [NUM_FILT],
   output logic [WORD_W-1:0] ref_o  [NUM_FILT]
);
   localparam int unsigned CNT_W = $clog2(BUSY_CYC + 1);

   logic [NUM_FILT-1:0] en_q;
   logic [CNT_W-1:0]    cnt_q;
   logic                en_wr;

   assign en_wr  = wr && (addr == ADDR_W'(ADR_ENABLE));
   assign busy_o = (cnt_q != '0);
   assign en_o   = en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (en_wr) begin
            en_q  <= wdata[NUM_FILT-1:0];
            cnt_q <= CNT_W'(BUSY_CYC);
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   for (genvar i = 0; i < NUM_FILT; i++) begin : g_filt
      logic [WORD_W-1:0] m_q, r_q;
      logic              open_w;
      assign open_w = wr && !busy_o && !en_q[i];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            m_q <= '0;
            r_q <= '0;
         end else if (open_w) begin
            if (addr == ADDR_W'(ADR_FBASE + 2*i))     m_q <= wdata;
            if (addr == ADDR_W'(ADR_FBASE + 2*i + 1)) r_q <= wdata;
         end
      end
      assign mask_o[i] = m_q;
      assign ref_o[i]  = r_q;
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(ADR_ENABLE)) rdata = WORD_W'(en_q);
      if (addr == ADDR_W'(ADR_STATUS)) rdata = WORD_W'(busy_o);
      for (int i = 0; i < NUM_FILT; i++) begin
         if (addr == ADDR_W'(ADR_FBASE + 2*i))     rdata = mask_o[i];
         if (addr == ADDR_W'(ADR_FBASE + 2*i + 1)) rdata = ref_o[i];
      end
   end
endmodule

// File: rtl/canaf_cmp.sv
module canaf_cmp
   import canaf_pkg::*;
#(
   parameter int unsigned WORD_W = 32
) (
   input  logic              en,
   input  logic [WORD_W-1:0] id,
   input  logic [WORD_W-1:0] mask,
   input  logic [WORD_W-1:0] refv,
   output logic              hit
);
   logic [WORD_W-1:0] eff;
   logic              std_only;

   // standard frame, or filter not asking for an IDE compare: base fields only
   assign std_only = !id[IDE_POS] || !mask[IDE_POS];
   assign eff      = std_only ? ext_clear(mask) : mask;
   assign hit      = en && (((id ^ refv) & eff) == '0);
endmodule

// File: rtl/canaf_decide.sv
module canaf_decide #(
   parameter int unsigned NUM_FILT = 4,
   parameter int unsigned IDX_W    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                vld,
   input  logic [NUM_FILT-1:0] en,
   input  logic [NUM_FILT-1:0] hit,
   output logic                dec_vld,
   output logic                dec_acc,
   output logic [IDX_W-1:0]    dec_idx
);
   logic [IDX_W-1:0] idx_w;
   logic             acc_w;

   always_comb begin
      idx_w = '0;
      for (int i = NUM_FILT - 1; i >= 0; i--) begin
         if (hit[i]) idx_w = IDX_W'(i);
      end
      acc_w = (en == '0) || (hit != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_vld <= 1'b0;
         dec_acc <= 1'b0;
         dec_idx <= '0;
      end else begin
         dec_vld <= vld;
         if (vld) begin
            dec_acc <= acc_w;
            dec_idx <= idx_w;
         end
      end
   end
endmodule

// File: rtl/can_accept_filter_bank.sv
module can_accept_filter_bank #(
   parameter int unsigned NUM_FILT = 4,
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned BUSY_CYC = 2,
   localparam int unsigned IDX_W   = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   output logic              busy_o,
   input  logic              frm_vld,
   input  logic [WORD_W-1:0] frm_id,
   output logic              dec_vld,
   output logic              dec_acc,
   output logic [IDX_W-1:0]  dec_idx
);
   if (WORD_W != 32) begin : g_bad_width
      $error("can_accept_filter_bank: identifier word must be 32 bits");
   end
   if (NUM_FILT < 1 || NUM_FILT > 32) begin : g_bad_count
      $error("can_accept_filter_bank: NUM_FILT out of range");
   end
   if (2 + 2*NUM_FILT > (1 << ADDR_W)) begin : g_bad_addr
      $error("can_accept_filter_bank: address space too small");
   end
   if (BUSY_CYC < 1) begin : g_bad_busy
      $error("can_accept_filter_bank: BUSY_CYC must be at least 1");
   end

   logic [NUM_FILT-1:0] en_w;
   logic [NUM_FILT-1:0] hit_w;
   logic [WORD_W-1:0]   mask_w [NUM_FILT];
   logic [WORD_W-1:0]   ref_w  [NUM_FILT];

   canaf_regs #(
      .NUM_FILT(NUM_FILT), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .en_o(en_w), .busy_o(busy_o), .mask_o(mask_w), .ref_o(ref_w)
   );

   for (genvar i = 0; i < NUM_FILT; i++) begin : g_cmp
      canaf_cmp #(.WORD_W(WORD_W)) u_cmp (
         .en(en_w[i]), .id(frm_id), .mask(mask_w[i]), .refv(ref_w[i]), .hit(hit_w[i])
      );
   end

   canaf_decide #(.NUM_FILT(NUM_FILT), .IDX_W(IDX_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .vld(frm_vld), .en(en_w), .hit(hit_w),
      .dec_vld(dec_vld), .dec_acc(dec_acc), .dec_idx(dec_idx)
   );
endmodule

// File: rtl/canaf_chk.sv
module canaf_chk #(
   parameter int unsigned NUM_FILT = 4,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned IDX_W    = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                reg_wr,
   input logic [ADDR_W-1:0]   reg_addr,
   input logic                busy_o,
   input logic                frm_vld,
   input logic                dec_vld,
   input logic                dec_acc,
   input logic [IDX_W-1:0]    dec_idx,
   input logic [NUM_FILT-1:0] en_q
);
   logic en_write;
   assign en_write = reg_wr && (reg_addr == '0);

   // R3: busy follows an enable write for two cycles
   a_r3_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
      en_write |=> busy_o);
   a_r3_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      en_write |=> ##1 busy_o);

   // R11: decision pulse tracks the strobe one edge later
   a_r11_dec_follows: assert property (@(posedge clk) disable iff (!rst_n)
      frm_vld |=> dec_vld);
   a_r11_dec_single: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_vld |=> !dec_vld);

   // R9: everything passes with the bank disabled
   a_r9_all_off_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_vld && en_q == '0) |=> (dec_acc && dec_idx == '0));

   // R8: a rejection is only possible with some filter enabled
   a_r8_reject_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_vld && !reg_wr) |=> (dec_acc || en_q != '0));
endmodule

bind can_accept_filter_bank canaf_chk #(
   .NUM_FILT(NUM_FILT), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .busy_o(busy_o),
   .frm_vld(frm_vld), .dec_vld(dec_vld), .dec_acc(dec_acc), .dec_idx(dec_idx),
   .en_q(en_w)
);

// File: tb/sim_can_accept_filter_bank.sv
`timescale 1ns/1ps
module sim_can_accept_filter_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        busy_o;
   logic        frm_vld = 1'b0;
   logic [31:0] frm_id = '0;
   logic        dec_vld, dec_acc;
   logic [1:0]  dec_idx;

   int checks = 0;
   int failures = 0;
   logic [31:0] mm [4];
   logic [31:0] mr [4];
   logic [3:0]  men;

   always #4 clk = ~clk;

   can_accept_filter_bank u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy_o(busy_o),
      .frm_vld(frm_vld), .frm_id(frm_id), .dec_vld(dec_vld), .dec_acc(dec_acc),
      .dec_idx(dec_idx)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
      reg_addr = a;
      #1;
      chk(reg_rdata == exp, req, reg_rdata, exp);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   // expected {acc, idx} from the requirement text
   function automatic logic [2:0] expect_dec(input logic [31:0] f, input logic [3:0] en);
      logic [2:0] r;
      r = {1'b0, 2'd0};
      if (en == 4'd0) return {1'b1, 2'd0};
      for (int i = 3; i >= 0; i--) begin
         logic [31:0] m;
         m = mm[i];
         if (f[19] == 1'b0 || m[19] == 1'b0) m[18:0] = '0;
         if (en[i] && ((f & m) == (mr[i] & m))) r = {1'b1, 2'(i)};
      end
      return r;
   endfunction

   task automatic send(input logic [31:0] f, input string req);
      logic [2:0] e;
      e = expect_dec(f, men);
      @(negedge clk);
      frm_vld = 1'b1; frm_id = f;
      @(negedge clk);
      frm_vld = 1'b0;
      chk(dec_vld == 1'b1, {req, " R11 dec_vld"}, 32'(dec_vld), 32'd1);
      chk(dec_acc == e[2], {req, " R8 dec_acc"}, 32'(dec_acc), 32'(e[2]));
      chk(dec_idx == e[1:0], {req, " R10 dec_idx"}, 32'(dec_idx), 32'(e[1:0]));
   endtask

   function automatic logic [31:0] gen_frame(input int i);
      logic [31:0] v;
      v = 32'(i) * 32'h9E3779B1 ^ 32'h5A5A0F0F;
      case (i % 4)
         0: v[31:21] = 11'h55E;
         1: v = {11'h123, v[20], 1'b1, 18'h2A5A5, v[0]};
         2: begin v[19] = 1'b1; v[15:0] = 16'h1234; end
         default: ;
      endcase
      return v;
   endfunction

   initial begin
      for (int i = 0; i < 4; i++) begin mm[i] = '0; mr[i] = '0; end
      men = '0;
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(busy_o == 1'b0, "R1 busy", 32'(busy_o), 0);
      chk(dec_vld == 1'b0, "R1 dec_vld", 32'(dec_vld), 0);
      for (int a = 0; a < 10; a++) rd_chk(4'(a), 32'd0, "R1 reset register");

      // R9 all disabled accepts anything
      send(32'hFFFF_FFFF, "R9 all-off");
      send(32'h0000_0000, "R9 all-off");
      @(negedge clk);
      chk(dec_vld == 1'b0, "R11 single pulse", 32'(dec_vld), 0);

      // program filters (bank disabled, not busy)
      mm[0] = 32'hFFF8_0000; mr[0] = 32'hABC0_0000;
      mm[1] = 32'hFFFF_FFFF; mr[1] = {11'h123, 1'b1, 1'b1, 18'h2A5A5, 1'b0};
      mm[2] = 32'hFFE0_0000; mr[2] = 32'hABC0_0000;
      mm[3] = 32'h0008_FFFF; mr[3] = 32'h0008_1234;
      for (int i = 0; i < 4; i++) begin
         wr(4'(2 + 2*i), mm[i]);
         wr(4'(3 + 2*i), mr[i]);
      end
      for (int i = 0; i < 4; i++) begin
         rd_chk(4'(2 + 2*i), mm[i], "R2 mask readback");
         rd_chk(4'(3 + 2*i), mr[i], "R2 ref readback");
      end

      // R3 busy window
      wr(4'd0, 32'hFFFF_FFF1);
      men = 4'h1;
      chk(busy_o == 1'b1, "R3 busy cycle 1", 32'(busy_o), 1);
      rd_chk(4'd1, 32'd1, "R2 R3 status busy");
      @(negedge clk);
      chk(busy_o == 1'b1, "R3 busy cycle 2", 32'(busy_o), 1);
      @(negedge clk);
      chk(busy_o == 1'b0, "R3 busy cleared", 32'(busy_o), 0);
      rd_chk(4'd0, 32'h1, "R2 enable upper bits zero");

      // R12 worked example on filter 0 alone
      send({11'h55E, 1'b0, 1'b0, 19'h0}, "R12 accept");
      send({11'h55E, 1'b0, 1'b0, 19'h7FFFF}, "R6 R12 ext bits ignored");
      send({11'h55E, 1'b1, 1'b0, 19'h0}, "R12 srr reject");
      send({11'h55F, 1'b0, 1'b0, 19'h0}, "R5 base mismatch");

      // R4 enabled filter rejects writes
      wr(4'd2, 32'h0);
      wr(4'd3, 32'h0);
      rd_chk(4'd2, mm[0], "R4 enabled mask kept");
      rd_chk(4'd3, mr[0], "R4 enabled ref kept");
      // R4 busy rejects writes even to a disabled filter
      wr(4'd0, 32'h0);
      men = 4'h0;
      reg_wr = 1'b1; reg_addr = 4'd4; reg_wdata = 32'h0;
      @(negedge clk);
      reg_wr = 1'b0;
      rd_chk(4'd4, mm[1], "R4 busy mask kept");
      idle(2);

      // R7 filter 2 (no IDE compare) matches extended frame on base only
      wr(4'd0, 32'h4); men = 4'h4; idle(2);
      send({11'h55E, 1'b1, 1'b1, 18'h3FFFF, 1'b1}, "R7 std-only filter");
      send({11'h55D, 1'b1, 1'b1, 18'h0, 1'b0}, "R7 base mismatch");
      // R6 filter 3 needs IDE: standard frame never compares low bits
      wr(4'd0, 32'h8); men = 4'h8; idle(2);
      send(32'h0008_1234, "R6 extended hit");
      send(32'h0000_1234, "R6 standard miss");

      // sweep all enable patterns (R5 R8 R10)
      for (int en = 0; en < 16; en++) begin
         wr(4'd0, 32'(en)); men = 4'(en); idle(2);
         for (int i = 0; i < 40; i++) send(gen_frame(i), "R5 sweep");
         send({11'h55E, 1'b0, 1'b0, 19'h0}, "R10 overlap");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule